// File: doc/BRIEF.md
# Dual-Channel Fault Tally and Hiccup Sequencer

This block holds the protection decisions for a pair of buck converter channels. On each switching cycle a one-clock strobe marks the moment when per-channel overcurrent and undervoltage comparator results are valid. Two shared saturating tallies collect those events. The first counts overcurrent and the second counts undervoltage. Each tally adds one for every channel that reports the fault on the strobe, so it adds two when both channels report. A tally that reaches its all-ones value shuts both channels down.

An overcurrent shutdown is not permanent. The block waits out a cool-down equal to the soft-start interval, measured in strobes. It then asks for a fresh soft-start and counts from zero again. This retry repeats for as long as the fault keeps coming back. An undervoltage overflow or a thermal flag causes a latched shutdown. Only the bias power-on reset clears it.

The analogue comparators, current sensing and the soft-start ramp are outside this block. It drives three registered flags: shutdown, a one-clock restart request, and latched-off.

Top module: `dual_fault_sequencer`

## Requirements
- R1: While and right after power-on reset (`por_n_i` low), `shut_o`, `restart_o` and `latched_o` are all 0.
- R2: During normal running, each strobe adds the number of channels with their `oc_i` bit set to the overcurrent tally. Clocks without `stb_i` leave the tally unchanged, whatever the fault inputs show.
- R3: A strobe during normal running on which no `oc_i` bit is set clears the overcurrent tally to zero, so up to 14 counts followed by a clean strobe never cause a shutdown.
- R4: When a strobe brings the overcurrent tally to 15 or more (CNT_W = 4), `shut_o` rises on the next clock. The block enters cool-down, and both tallies are cleared.
- R5: Cool-down lasts COOL_STB strobes. On the clock after the last of them, `shut_o` falls and `restart_o` is 1 for exactly one clock.
- R6: During cool-down the overcurrent and undervoltage inputs have no effect: the tallies do not move, and the cool-down length is unchanged.
- R7: After a restart the overcurrent tally must again reach 15 from zero before the next shutdown. The shutdown, cool-down and restart sequence repeats without limit.
- R8: The undervoltage tally adds one per channel with its `uv_i` bit set on each strobe during normal running. It clears on a strobe with no `uv_i` bit set.
- R9: When a strobe brings the undervoltage tally to 15 or more, `shut_o` and `latched_o` go to 1 on the next clock. They stay there regardless of any input until `por_n_i` is asserted.
- R10: `hot_i` high on any clock, with or without a strobe and in any state, gives `shut_o` = `latched_o` = 1 on the next clock. It also cancels a restart due on that clock.
- R11: If both tallies overflow on the same strobe, the latched shutdown wins over the overcurrent retry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| por_n_i | input | 1 | Bias power-on reset, asynchronous, active low |
| stb_i | input | 1 | One-clock strobe per switching cycle; fault inputs are sampled on it |
| oc_i | input | NCH | Per-channel overcurrent flag, 1 = over limit |
| uv_i | input | NCH | Per-channel undervoltage flag, 1 = under the trip level |
| hot_i | input | 1 | Die over-temperature flag |
| shut_o | output | 1 | Both channels held off |
| restart_o | output | 1 | One-clock request to start a new soft-start |
| latched_o | output | 1 | Latched shutdown, cleared only by power-on reset |

## Verification
The bench builds the block with two channels, a 4-bit tally and a cool-down of 4 strobes. The 4-bit tally makes the exact overflow boundary reachable in a few clocks: 14 counts with no trip, 15 counts reached by single steps, and 14 plus a double step. The short cool-down lets several hiccup rounds happen back to back. Both tallies overflowing on one strobe is set up deliberately. Thermal trips are applied both inside cool-down and outside a strobe.

// File: rtl/fg_pkg.sv
package fg_pkg;

   typedef enum logic [1:0] {
      FG_RUN   = 2'd0,
      FG_COOL  = 2'd1,
      FG_LATCH = 2'd2
   } fg_state_e;

endpackage

// File: rtl/fg_shared_tally.sv
module fg_shared_tally #(
   parameter int NCH      = 2,
   parameter int CNT_W    = 4,
   parameter bit CLR_IDLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic [NCH-1:0]   hits_i,
   output logic             ovf_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int SUM_W = CNT_W + $clog2(NCH + 1);
   localparam logic [SUM_W-1:0] TOPV = SUM_W'((1 << CNT_W) - 1);

   logic [SUM_W-1:0] add_w;
   logic [SUM_W-1:0] sum_w;
   logic [CNT_W-1:0] idle_val;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      add_w = '0;
      for (int i = 0; i < NCH; i++) begin
         add_w = add_w + SUM_W'(hits_i[i]);
      end
      sum_w = SUM_W'(cnt_q) + add_w;
   end

   generate
      if (CLR_IDLE) begin : g_clear_idle
         assign idle_val = '0;
      end else begin : g_hold_idle
         assign idle_val = cnt_q;
      end
   endgenerate

   assign ovf_o = en_i && (add_w != '0) && (sum_w >= TOPV);

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (add_w == '0) begin
            cnt_q <= idle_val;
         end else if (ovf_o) begin
            cnt_q <= TOPV[CNT_W-1:0];
         end else begin
            cnt_q <= sum_w[CNT_W-1:0];
         end
      end
   end

   assign cnt_o = cnt_q;

   // R2 / R6: a tally that is neither enabled nor cleared keeps its value
   a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!en_i && !clr_i) |=> $stable(cnt_o));

   // R4: a clear always lands at zero
   a_r4_clear_to_zero: assert property (@(posedge clk_i) disable iff (!por_n_i)
      clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/fg_cool_timer.sv
module fg_cool_timer #(
   parameter int COOL_STB = 4000
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic run_i,
   input  logic stb_i,
   output logic done_o
);

   localparam int TW = $clog2(COOL_STB + 1);
   localparam logic [TW-1:0] LAST = TW'(COOL_STB - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (stb_i) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

   assign done_o = run_i && stb_i && (cnt_q == LAST);

   // R5: the count never runs past the last strobe of the window
   a_r5_timer_in_range: assert property (@(posedge clk_i) disable iff (!por_n_i)
      run_i |-> (cnt_q <= LAST));

endmodule

// File: rtl/dual_fault_sequencer.sv
module dual_fault_sequencer #(
   parameter int NCH      = 2,
   parameter int CNT_W    = 4,
   parameter int COOL_STB = 4000
) (
   input  logic           clk_i,
   input  logic           por_n_i,
   input  logic           stb_i,
   input  logic [NCH-1:0] oc_i,
   input  logic [NCH-1:0] uv_i,
   input  logic           hot_i,
   output logic           shut_o,
   output logic           restart_o,
   output logic           latched_o
);
   import fg_pkg::*;

   generate
      if (NCH < 1 || CNT_W < 2 || COOL_STB < 1) begin : g_bad_cfg
         $error("dual_fault_sequencer: NCH >= 1, CNT_W >= 2 and COOL_STB >= 1 are required");
      end
   endgenerate

   fg_state_e        st_q;
   fg_state_e        st_d;
   logic             restart_q;
   logic             in_run;
   logic             in_cool;
   logic             tally_en;
   logic             oc_ovf;
   logic             uv_ovf;
   logic             go_latch;
   logic             go_cool;
   logic             cool_done;
   logic [CNT_W-1:0] oc_cnt;
   logic [CNT_W-1:0] uv_cnt;

   assign in_run   = (st_q == FG_RUN);
   assign in_cool  = (st_q == FG_COOL);
   assign tally_en = stb_i && in_run;
   assign go_latch = hot_i || uv_ovf;
   assign go_cool  = oc_ovf && !go_latch;

   fg_shared_tally #(.NCH(NCH), .CNT_W(CNT_W), .CLR_IDLE(1'b1)) u_oc_tally (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .en_i    (tally_en),
      .clr_i   (go_cool),
      .hits_i  (oc_i),
      .ovf_o   (oc_ovf),
      .cnt_o   (oc_cnt)
   );

   fg_shared_tally #(.NCH(NCH), .CNT_W(CNT_W), .CLR_IDLE(1'b1)) u_uv_tally (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .en_i    (tally_en),
      .clr_i   (go_cool),
      .hits_i  (uv_i),
      .ovf_o   (uv_ovf),
      .cnt_o   (uv_cnt)
   );

   fg_cool_timer #(.COOL_STB(COOL_STB)) u_cool (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .run_i   (in_cool),
      .stb_i   (stb_i),
      .done_o  (cool_done)
   );

   always_comb begin
      st_d = st_q;
      if (st_q == FG_LATCH) begin
         st_d = FG_LATCH;
      end else if (go_latch) begin
         st_d = FG_LATCH;
      end else if (in_run && go_cool) begin
         st_d = FG_COOL;
      end else if (in_cool && cool_done) begin
         st_d = FG_RUN;
      end
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         st_q      <= FG_RUN;
         restart_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         restart_q <= in_cool && cool_done && !hot_i;
      end
   end

   assign shut_o    = (st_q != FG_RUN);
   assign latched_o = (st_q == FG_LATCH);
   assign restart_o = restart_q;

   // R5: the restart request is a single clock wide
   a_r5_restart_single: assert property (@(posedge clk_i) disable iff (!por_n_i)
      restart_o |=> !restart_o);

   // R5: a restart request comes out of cool-down, with the channels released
   a_r5_restart_after_cool: assert property (@(posedge clk_i) disable iff (!por_n_i)
      restart_o |-> (!shut_o && $past(shut_o)));

   // R4: an unlatched shutdown only begins on a strobe
   a_r4_shut_on_strobe: assert property (@(posedge clk_i) disable iff (!por_n_i)
      ($rose(shut_o) && !latched_o) |-> $past(stb_i));

   // R9: latched-off persists until power-on reset
   a_r9_latch_sticky: assert property (@(posedge clk_i) disable iff (!por_n_i)
      latched_o |=> latched_o);

   // R9: latched-off always implies shutdown
   a_r9_latch_implies_shut: assert property (@(posedge clk_i) disable iff (!por_n_i)
      latched_o |-> shut_o);

   // R10: an over-temperature flag latches the block on the next clock
   a_r10_hot_latches: assert property (@(posedge clk_i) disable iff (!por_n_i)
      hot_i |=> latched_o);

   // R6: the tallies stay frozen during cool-down
   a_r6_frozen_in_cool: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (in_cool && $past(in_cool)) |-> (oc_cnt == '0 && uv_cnt == '0));

endmodule

// File: tb/dual_fault_sequencer_bench.sv
`timescale 1ns/1ps
module dual_fault_sequencer_bench;

   localparam int NCH   = 2;
   localparam int CW    = 4;
   localparam int COOL  = 4;
   localparam int TOPC  = 15;

   logic           clk = 1'b0;
   logic           por_n = 1'b0;
   logic           stb = 1'b0;
   logic [NCH-1:0] oc = '0;
   logic [NCH-1:0] uv = '0;
   logic           hot = 1'b0;
   logic           shut;
   logic           restart;
   logic           latched;

   int    n_vec  = 0;
   int    n_fail = 0;
   string tag    = "R1";

   // reference model state: 0 run, 1 cool-down, 2 latched
   int m_st   = 0;
   int m_oc   = 0;
   int m_uv   = 0;
   int m_cool = 0;
   int m_rs   = 0;

   always #5 clk = ~clk;

   dual_fault_sequencer #(.NCH(NCH), .CNT_W(CW), .COOL_STB(COOL)) u_dual_fault_sequencer (
      .clk_i     (clk),
      .por_n_i   (por_n),
      .stb_i     (stb),
      .oc_i      (oc),
      .uv_i      (uv),
      .hot_i     (hot),
      .shut_o    (shut),
      .restart_o (restart),
      .latched_o (latched)
   );

   task automatic model_reset();
      m_st = 0; m_oc = 0; m_uv = 0; m_cool = 0; m_rs = 0;
   endtask

   task automatic model_clock(input logic s, input logic [NCH-1:0] o,
                              input logic [NCH-1:0] u, input logic h);
      int no = $countones(o);
      int nu = $countones(u);
      m_rs = 0;
      if (m_st == 2) begin
         m_st = 2;
      end else if (h) begin
         m_st = 2;
      end else if (m_st == 0) begin
         if (s) begin
            m_oc = (no == 0) ? 0 : m_oc + no;
            m_uv = (nu == 0) ? 0 : m_uv + nu;
            if (m_uv >= TOPC) begin
               m_st = 2;
            end else if (m_oc >= TOPC) begin
               m_st = 1; m_oc = 0; m_uv = 0; m_cool = 0;
            end
         end
      end else begin
         if (s) begin
            m_cool++;
            if (m_cool == COOL) begin
               m_st = 0; m_rs = 1;
            end
         end
      end
   endtask

   task automatic check_outputs();
      logic es, er, el;
      es = (m_st != 0);
      er = (m_rs != 0);
      el = (m_st == 2);
      n_vec++;
      if (shut !== es || restart !== er || latched !== el) begin
         n_fail++;
         $display("FAIL %s shut/restart/latched got %b%b%b expected %b%b%b at %0t",
                  tag, shut, restart, latched, es, er, el, $time);
      end
   endtask

   // drive at a falling edge, model at the rising edge, compare at the next falling edge
   task automatic step(input logic s, input logic [NCH-1:0] o,
                       input logic [NCH-1:0] u, input logic h);
      stb = s; oc = o; uv = u; hot = h;
      @(posedge clk);
      model_clock(s, o, u, h);
      @(negedge clk);
      check_outputs();
   endtask

   task automatic do_por();
      stb = 1'b0; oc = '0; uv = '0; hot = 1'b0;
      por_n = 1'b0;
      #1;
      model_reset();
      check_outputs();
      @(negedge clk);
      check_outputs();
      por_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired in phase %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      // R1: outputs quiet under reset
      tag = "R1";
      model_reset();
      repeat (3) begin
         @(negedge clk);
         check_outputs();
      end
      por_n = 1'b1;
      step(1'b0, '0, '0, 1'b0);

      // R3: 14 counts, a clean strobe clears, 14 more stay below the trip
      tag = "R3";
      repeat (14) step(1'b1, 2'b01, 2'b00, 1'b0);
      step(1'b1, 2'b00, 2'b00, 1'b0);
      repeat (14) step(1'b1, 2'b10, 2'b00, 1'b0);

      // R2: faults between strobes are not counted
      tag = "R2";
      repeat (5) step(1'b0, 2'b11, 2'b11, 1'b0);

      // R4: the 15th count trips the shutdown
      tag = "R4";
      step(1'b1, 2'b01, 2'b00, 1'b0);

      // R6 and R5: faults during cool-down are ignored, restart after 4 strobes
      tag = "R6";
      for (int i = 0; i < 8; i++) step(1'(i % 2), 2'b11, 2'b11, 1'b0);
      tag = "R5";
      repeat (2) step(1'b0, 2'b00, 2'b00, 1'b0);

      // R7: the retry needs a fresh 15 counts, then repeats
      tag = "R7";
      repeat (7) step(1'b1, 2'b11, 2'b00, 1'b0);
      step(1'b1, 2'b01, 2'b00, 1'b0);
      for (int i = 0; i < 9; i++) step(1'(i % 2), 2'b00, 2'b00, 1'b0);
      repeat (8) step(1'b1, 2'b11, 2'b00, 1'b0);
      repeat (6) step(1'b1, 2'b00, 2'b00, 1'b0);

      // R8: undervoltage counts per channel and clears on a clean strobe
      tag = "R8";
      repeat (7) step(1'b1, 2'b00, 2'b11, 1'b0);
      step(1'b1, 2'b00, 2'b00, 1'b0);
      repeat (14) step(1'b1, 2'b00, 2'b01, 1'b0);

      // R9: overflow latches, nothing but reset releases it
      tag = "R9";
      step(1'b1, 2'b00, 2'b10, 1'b0);
      repeat (10) step(1'b1, 2'b00, 2'b00, 1'b0);
      do_por();
      step(1'b0, 2'b00, 2'b00, 1'b0);

      // R10: thermal flag during cool-down, then without a strobe while running
      tag = "R10";
      repeat (8) step(1'b1, 2'b11, 2'b00, 1'b0);
      step(1'b1, 2'b00, 2'b00, 1'b0);
      step(1'b0, 2'b00, 2'b00, 1'b1);
      repeat (4) step(1'b1, 2'b00, 2'b00, 1'b0);
      do_por();
      step(1'b0, 2'b00, 2'b00, 1'b0);
      step(1'b0, 2'b00, 2'b00, 1'b1);
      repeat (3) step(1'b0, 2'b00, 2'b00, 1'b0);
      do_por();

      // R10: thermal flag on the very strobe that ends cool-down cancels the restart
      repeat (8) step(1'b1, 2'b11, 2'b00, 1'b0);
      repeat (3) step(1'b1, 2'b00, 2'b00, 1'b0);
      step(1'b1, 2'b00, 2'b00, 1'b1);
      repeat (2) step(1'b0, 2'b00, 2'b00, 1'b0);
      do_por();

      // R11: both tallies overflow on one strobe, latch wins
      tag = "R11";
      repeat (7) step(1'b1, 2'b11, 2'b11, 1'b0);
      step(1'b1, 2'b01, 2'b01, 1'b0);
      repeat (6) step(1'b1, 2'b00, 2'b00, 1'b0);
      do_por();
      step(1'b0, 2'b00, 2'b00, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule